// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is the external bus front end of an 8-bit controller with a 16-bit address space. It accepts one access at a time from the core: a code fetch, a data read or a data write. It then runs the matching cycle on the pins. A shared byte-wide port first carries the low address byte, framed by an address-latch pulse that an external latch uses to capture it. The same port then carries the data. A second port drives the high address byte for the whole cycle. Code reads use a program-store strobe. Data reads and data writes use their own read and write strobes. All strobes are active low.

Code fetches can also be served from on-chip ROM. When the on-chip ROM enable pin is high and the fetch address is below 1000h, the controller reads the internal ROM and runs no external cycle. Any other fetch goes to the external bus, and so does every data access. Data memory has its own full 64K space.

The core side uses valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the controller is idle. There is no back-pressure on the bus pins. The response is held, with stable data, until `rsp_ready` accepts it. Only after that does the controller take the next request.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `p0_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A fetch with `req_code`=1, `int_rom_en`=1 and an address below 1000h is served from the internal ROM. `rsp_rdata` equals `rom_data` for `rom_addr` = address bits 11:0, and no address-latch pulse or strobe occurs.
- R3: With `int_rom_en`=0, every code fetch, including those to 0000h–0FFFh, runs an external cycle that uses `psen_n`.
- R4: A code fetch to 1000h–FFFFh always runs an external `psen_n` cycle, whatever the value of `int_rom_en`.
- R5: An external cycle starts with `ale` high for exactly ADDR_CLKS clocks. During that time `p0_oe` is 1, `p0_out` carries address bits 7:0, and `p2_out` carries address bits 15:8, which it keeps until the next cycle.
- R6: After `ale` falls, exactly one strobe is low for exactly STROBE_CLKS clocks. No strobe is ever low while `ale` is high, and never are two strobes low together.
- R7: A data read (`req_code`=0, `req_write`=0) uses `rd_n`. `p0_oe` is 0 while the strobe is low. The returned byte is `p0_in` as sampled on the last clock edge before the strobe rises.
- R8: A data write (`req_code`=0, `req_write`=1) uses `wr_n`. `p0_out` carries the write data with `p0_oe`=1 for the whole time `wr_n` is low and for one clock after it rises.
- R9: `req_ready` is high only while no access is in progress and no response is waiting.
- R10: Every access, write included, ends with `rsp_valid`. While `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` stays unchanged.
- R11: `req_write` has no effect when `req_code`=1. The access is a code fetch using `psen_n`, and `wr_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_rom_en | input | 1 | 1: low 4K of code space is served by on-chip ROM |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1: data write, 0: read |
| req_code | input | 1 | 1: code fetch, 0: data access |
| rsp_valid | output | 1 | Access finished, response pending |
| rsp_ready | input | 1 | Core accepts the response |
| rsp_rdata | output | 8 | Read data |
| rom_addr | output | 12 | On-chip ROM address |
| rom_data | input | 8 | On-chip ROM data (combinational) |
| p0_out | output | 8 | Shared port: low address, then data |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | 8 | Shared port input |
| p2_out | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions assume that the core holds a response until it accepts it. They also assume that `rst_n` is applied before the first clock. The strobe, port-direction and response-stability properties then depend only on the controller's own state. The bench keeps to these assumptions. Its driver raises `req_valid` only between responses and keeps it up until the handshake. `rsp_ready` comes from a free-running pattern that is sometimes held low for three of every four clocks. The external memory model responds only while a strobe is low.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_RESP
  } xm_state_e;

  typedef enum logic [1:0] {
    K_CODE,
    K_READ,
    K_WRITE
  } xm_kind_e;
endpackage

// File: rtl/xmem_route.sv
// Decides whether a fetch is answered by on-chip ROM.
module xmem_route #(
  parameter int HI_W = 4
) (
  input  logic            is_code,
  input  logic            int_rom_en,
  input  logic [HI_W-1:0] addr_hi,
  output logic            to_rom
);
  always_comb to_rom = is_code && int_rom_en && (addr_hi == '0);
endmodule

// File: rtl/xmem_phase_cnt.sv
// Counts clocks spent in the current bus phase.
module xmem_phase_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ROM_BYTES   = 4096,
  parameter int ADDR_CLKS   = 2,
  parameter int STROBE_CLKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  int_rom_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2*DATA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  req_write,
  input  logic                  req_code,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [$clog2(ROM_BYTES)-1:0] rom_addr,
  input  logic [DATA_W-1:0]     rom_data,
  output logic [DATA_W-1:0]     p0_out,
  output logic                  p0_oe,
  input  logic [DATA_W-1:0]     p0_in,
  output logic [DATA_W-1:0]     p2_out,
  output logic                  ale,
  output logic                  psen_n,
  output logic                  rd_n,
  output logic                  wr_n
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam int PH_MAX = (ADDR_CLKS > STROBE_CLKS) ? ADDR_CLKS : STROBE_CLKS;
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CLKS - 1);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STROBE_CLKS - 1);

  xm_state_e           state, nxt;
  xm_kind_e            kind_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [CNT_W-1:0]    cnt;
  logic                to_rom;
  logic                accept;
  logic                strb_on;

  xmem_route #(.HI_W(ADDR_W - ROM_AW)) i_route (
    .is_code    (req_code),
    .int_rom_en (int_rom_en),
    .addr_hi    (req_addr[ADDR_W-1:ROM_AW]),
    .to_rom     (to_rom)
  );

  xmem_phase_cnt #(.W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nxt != state),
    .cnt   (cnt)
  );

  assign accept   = (state == ST_IDLE) && req_valid;
  assign rom_addr = req_addr[ROM_AW-1:0];

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_valid) nxt = to_rom ? ST_RESP : ST_ADDR;
      ST_ADDR: if (cnt == ADDR_LAST) nxt = ST_STRB;
      ST_STRB: if (cnt == STRB_LAST) nxt = (kind_q == K_WRITE) ? ST_HOLD : ST_RESP;
      ST_HOLD: nxt = ST_RESP;
      ST_RESP: if (rsp_ready) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_q  <= K_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        kind_q  <= req_code ? K_CODE : (req_write ? K_WRITE : K_READ);
        if (to_rom) rdata_q <= rom_data;
      end
      if (state == ST_STRB && cnt == STRB_LAST && kind_q != K_WRITE)
        rdata_q <= p0_in;
    end
  end

  assign strb_on   = (state == ST_STRB);
  assign ale       = (state == ST_ADDR);
  assign psen_n    = !(strb_on && kind_q == K_CODE);
  assign rd_n      = !(strb_on && kind_q == K_READ);
  assign wr_n      = !(strb_on && kind_q == K_WRITE);
  assign p0_oe     = ale || ((strb_on || state == ST_HOLD) && kind_q == K_WRITE);
  assign p0_out    = ale ? addr_q[DATA_W-1:0] : wdata_q;
  assign p2_out    = addr_q[ADDR_W-1:DATA_W];
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/xmem_bus_chk.sv
module xmem_bus_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              p0_oe,
  input logic [DATA_W-1:0] p0_out,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R6
  AST_QUIET_DURING_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n)); // R6
  AST_ALE_DRIVES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> p0_oe); // R5
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !p0_oe); // R7
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe); // R8
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out))); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !ale && psen_n && rd_n && wr_n && !p0_oe)); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
endmodule

bind xmem_bus_ctrl xmem_bus_chk #(.DATA_W(DATA_W)) i_xmem_bus_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .p0_oe     (p0_oe),
  .p0_out    (p0_out),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module test_xmem_bus_ctrl;
  localparam int AC = 2;
  localparam int SC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_rom_en = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_write = 1'b0;
  logic req_code = 1'b0;
  logic rsp_valid;
  logic rsp_ready;
  logic [7:0] rsp_rdata;
  logic [11:0] rom_addr;
  logic [7:0] rom_data;
  logic [7:0] p0_out;
  logic p0_oe;
  logic [7:0] p0_in = '0;
  logic [7:0] p2_out;
  logic ale, psen_n, rd_n, wr_n;

  always #2.5 clk = ~clk;

  xmem_bus_ctrl #(.ADDR_CLKS(AC), .STROBE_CLKS(SC)) i_xmem_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .int_rom_en(int_rom_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_code(req_code),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] rom_f(logic [11:0] a);
    return a[7:0] + {a[11:8], 4'h0} + 8'h11;
  endfunction
  function automatic logic [7:0] code_f(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hC3;
  endfunction
  function automatic logic [7:0] data_f(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rom_data = rom_f(rom_addr);

  // back-pressure pattern
  logic [1:0] rcnt = '0;
  logic bp_mode = 1'b0;
  always @(posedge clk) rcnt <= rcnt + 2'd1;
  assign rsp_ready = bp_mode ? (rcnt == 2'd3) : 1'b1;

  int n_tests = 0;
  int n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  wdata;
    bit          ext;
    bit [1:0]    kind;   // 0 code, 1 read, 2 write
  } item_t;
  item_t sb[$];
  logic [7:0] shadow [int];

  // external memory model and bus monitor
  logic [7:0] lat_lo = '0;
  logic [7:0] dmem [int];
  logic prev_ale = 0, prev_psen = 1, prev_rd = 1, prev_wr = 1;
  int ale_n = 0, psen_f = 0, rd_f = 0, wr_f = 0;
  int ale_run = 0, strb_run = 0, ale_w = 0, strb_w = 0;
  int ale_base = 0, psen_base = 0, rd_base = 0, wr_base = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) lat_lo <= p0_out;
      if (!psen_n)   p0_in <= code_f({p2_out, lat_lo});
      else if (!rd_n) p0_in <= dmem.exists(int'({p2_out, lat_lo})) ?
                               dmem[int'({p2_out, lat_lo})] : data_f({p2_out, lat_lo});
      else            p0_in <= 8'h00;
      if (ale && !prev_ale) ale_n++;
      if (!psen_n && prev_psen) psen_f++;
      if (!rd_n && prev_rd) rd_f++;
      if (!wr_n && prev_wr) wr_f++;
      if (ale) ale_run++; else if (ale_run > 0) begin ale_w = ale_run; ale_run = 0; end
      if (!(psen_n && rd_n && wr_n)) strb_run++;
      else if (strb_run > 0) begin strb_w = strb_run; strb_run = 0; end
      if (wr_n && !prev_wr) begin
        // R8: data still driven in the clock after the write strobe rises
        chk(p0_oe === 1'b1 && sb.size() > 0 && p0_out === sb[0].wdata, "R8 hold",
            {p0_oe, p0_out}, {1'b1, sb.size() > 0 ? sb[0].wdata : 8'h00});
        dmem[int'({p2_out, lat_lo})] = p0_out;
      end
      if (rsp_valid) chk(req_ready == 1'b0, "R9 busy", req_ready, 0);
      if (rsp_valid && rsp_ready && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        if (it.kind != 2)
          chk(rsp_rdata === it.data, "R2/R3/R4/R7 data", rsp_rdata, it.data);
        chk(ale_n - ale_base == (it.ext ? 1 : 0), "R2/R5 bus cycle", ale_n - ale_base, it.ext);
        chk(psen_f - psen_base == ((it.ext && it.kind == 0) ? 1 : 0), "R3/R4/R11 psen",
            psen_f - psen_base, (it.ext && it.kind == 0));
        chk(rd_f - rd_base == ((it.kind == 1) ? 1 : 0), "R7 rd", rd_f - rd_base, it.kind == 1);
        chk(wr_f - wr_base == ((it.kind == 2) ? 1 : 0), "R8/R11 wr", wr_f - wr_base, it.kind == 2);
        if (it.ext) begin
          chk(ale_w == AC, "R5 ale width", ale_w, AC);
          chk({p2_out, lat_lo} === it.addr, "R5 address", {p2_out, lat_lo}, it.addr);
          chk(strb_w == SC, "R6 strobe width", strb_w, SC);
        end
        ale_base = ale_n; psen_base = psen_f; rd_base = rd_f; wr_base = wr_f;
      end
    end
    prev_ale = ale; prev_psen = psen_n; prev_rd = rd_n; prev_wr = wr_n;
  end

  task automatic issue(input logic [15:0] a, input bit code, input bit wr, input logic [7:0] wd);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_code = code; req_write = wr; req_wdata = wd;
    it.addr = a; it.wdata = wd;
    if (code) begin
      it.kind = 0;
      it.ext  = !(int_rom_en && a < 16'h1000);
      it.data = it.ext ? code_f(a) : rom_f(a[11:0]);
    end else if (wr) begin
      it.kind = 2; it.ext = 1; it.data = 8'h00;
      shadow[int'(a)] = wd;
    end else begin
      it.kind = 1; it.ext = 1;
      it.data = shadow.exists(int'(a)) ? shadow[int'(a)] : data_f(a);
    end
    sb.push_back(it);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    // R1: idle pin state under reset
    chk(ale == 0 && psen_n && rd_n && wr_n && !p0_oe, "R1 pins", {ale, psen_n, rd_n, wr_n, p0_oe}, 5'b01110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R1 handshake", {req_ready, rsp_valid}, 2'b10);

    int_rom_en = 1'b1;
    issue(16'h0000, 1, 0, 0);    // R2 internal
    issue(16'h0FFF, 1, 0, 0);    // R2 top of ROM
    issue(16'h1000, 1, 0, 0);    // R4 first external code
    issue(16'hFFFF, 1, 0, 0);    // R4
    int_rom_en = 1'b0;
    issue(16'h0000, 1, 0, 0);    // R3
    issue(16'h0ABC, 1, 0, 0);    // R3
    issue(16'h0010, 0, 1, 8'hA7); // R8 write
    issue(16'hFFFF, 0, 1, 8'h3C); // R8 write top
    issue(16'h0010, 0, 0, 0);    // R7 read back
    issue(16'hFFFF, 0, 0, 0);    // R7 read back
    issue(16'h1234, 0, 0, 0);    // R7 unwritten
    int_rom_en = 1'b1;
    issue(16'h0020, 1, 1, 8'hEE); // R11 code with write flag, internal
    issue(16'h2000, 1, 1, 8'hEE); // R11 code with write flag, external
    bp_mode = 1'b1;               // R10 back-pressure
    issue(16'h0123, 1, 0, 0);
    issue(16'h4321, 1, 0, 0);
    issue(16'h0010, 0, 1, 8'h5D);
    issue(16'h0010, 0, 0, 0);
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule